// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter Chain

This block is the counting core of a real-time clock. A one-cycle tick at 100 Hz advances a chain of BCD fields: hundredths, seconds, minutes, hours, day of week, date, month and year. A century flag sits on top of the chain. Month lengths and leap years are worked out from the stored month and year. Every carry ripples through the whole chain in the clock cycle that takes the tick.

Software-facing logic sets the time through a single write port. The port takes a 3-bit word address and an 8-bit data word. The counting core holds the internal copy of all fields and drives it straight out on its ports. A stop flag in the seconds word freezes counting. An enable flag in the hours word lets the century flag flip when the year wraps. Any write restarts the sub-second count, so the first second after a time is set lasts a full 100 ticks. `adv_o` pulses for one cycle each time the count moves.

Top module: `rtc_bcd_chain`

## Requirements
- R1: After reset the fields are hundredths 00, seconds 00, minutes 00, hours 00, day of week 1, date 01, month 01, year 00. The century flag, century enable, stop flag and `adv_o` are all 0.
- R2: Each accepted tick raises hundredths by one in BCD. From 99 it returns to 00 and carries into seconds. Seconds and minutes count 00 to 59 and carry on wrap.
- R3: Hours count 00 to 23. The wrap from 23 to 00 advances the day of week, which runs 1 to 7 and returns to 1, and advances the date.
- R4: The date wraps to 01 after the last day of the month. That day is 31 for months 01, 03, 05, 07, 08, 10 and 12, and 30 for months 04, 06, 09 and 11. For month 02 it is 29 when the BCD year is a multiple of four (00 included) and 28 otherwise.
- R5: Month counts 01 to 12. The wrap from 12 to 01 raises the year. The year counts 00 to 99 and wraps to 00.
- R6: When century enable is 1, the century flag inverts on the year wrap from 99 to 00. When enable is 0, the flag changes only by a write.
- R7: While the stop flag is 1, ticks change no field and `adv_o` stays 0. After the flag is written back to 0, ticks count again.
- R8: Any write forces hundredths to 00, whatever the address and data. A write to address 0 cannot load any other value. Seconds therefore next advance on the 100th tick after the write.
- R9: When a write and a tick arrive in the same cycle, the write is applied and the tick is dropped. No field advances and `adv_o` stays 0.
- R10: `adv_o` is 1 for exactly the one cycle after each accepted tick, the same cycle in which the advanced values first appear. Otherwise it is 0.
- R11: Word layout, by address:
  - 0: hundredths.
  - 1: bit 7 is the stop flag, bits 6:0 are seconds.
  - 2: bits 6:0 are minutes.
  - 3: bit 7 is the century flag, bit 6 is century enable, bits 5:0 are hours.
  - 4: bits 2:0 are the day of week.
  - 5: bits 5:0 are the date.
  - 6: bits 4:0 are the month.
  - 7: the year.

  Data bits outside these fields are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | 100 Hz tick, one cycle wide |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 3 | Word address of the write |
| wr_data_i | input | 8 | Write data |
| hund_o | output | 8 | Hundredths, BCD |
| sec_o | output | 7 | Seconds, BCD |
| stop_o | output | 1 | Stop flag |
| min_o | output | 7 | Minutes, BCD |
| hour_o | output | 6 | Hours, BCD |
| cent_o | output | 1 | Century flag |
| cent_en_o | output | 1 | Century enable |
| dow_o | output | 3 | Day of week, 1 to 7 |
| date_o | output | 6 | Date, BCD |
| month_o | output | 5 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| adv_o | output | 1 | One-cycle pulse when the count advances |

## Verification
Two events can land in the same cycle: a write from the set-time path and a tick from the prescaler. The bench runs the count to a nonzero hundredths value. It then asserts a minutes write and a tick on the same edge. The result must show the written minutes, hundredths at 00 and no `adv_o` pulse, so the dropped tick leaves no trace. A second collision, a write to the stop flag while it is set, is judged by confirming that later ticks stay frozen until the flag is written back to 0.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned N_WORDS = 1 << ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    A_HUND, A_SEC, A_MIN, A_HOUR, A_DOW, A_DATE, A_MONTH, A_YEAR
  } rtc_addr_e;

  // BCD year divisible by 4: even tens need units 0/4/8, odd tens need 2/6
  function automatic logic bcd_leap(input logic [7:0] y);
    if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int unsigned W     = 8,
  parameter logic [W-1:0] FLOOR = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic [W-1:0] ceil_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);
  logic [W-1:0] val_q, val_inc;

  generate
    if (W <= 4) begin : g_bin
      assign val_inc = val_q + W'(1);
    end else begin : g_bcd
      always_comb begin
        if (val_q[3:0] >= 4'd9) val_inc = {val_q[W-1:4] + (W-4)'(1), 4'd0};
        else                    val_inc = {val_q[W-1:4], val_q[3:0] + 4'd1};
      end
    end
  endgenerate

  // >= so an over-range write still wraps
  assign wrap_o = inc_i && (val_q >= ceil_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    val_q <= FLOOR;
    else if (ld_i)  val_q <= ld_val_i;
    else if (inc_i) val_q <= wrap_o ? FLOOR : val_inc;
  end

  assign val_o = val_q;
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [4:0] month_i,
  input  logic [7:0] year_i,
  output logic [5:0] last_day_o
);
  always_comb begin
    unique case (month_i)
      5'h02:                      last_day_o = rtc_pkg::bcd_leap(year_i) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day_o = 6'h30;
      default:                    last_day_o = 6'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_chain.sv
module rtc_bcd_chain
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [7:0]        hund_o,
  output logic [6:0]        sec_o,
  output logic              stop_o,
  output logic [6:0]        min_o,
  output logic [5:0]        hour_o,
  output logic              cent_o,
  output logic              cent_en_o,
  output logic [2:0]        dow_o,
  output logic [5:0]        date_o,
  output logic [4:0]        month_o,
  output logic [7:0]        year_o,
  output logic              adv_o
);
  logic [N_WORDS-1:0] ld;
  logic step, w_hund, w_sec, w_min, w_hour, w_date, w_month, w_year;
  logic stop_q, cent_q, cent_en_q, adv_q;
  logic [2:0] dow_q;
  logic [5:0] last_day;

  generate
    for (genvar i = 0; i < N_WORDS; i++) begin : g_ld
      assign ld[i] = wr_en_i && (wr_addr_i == ADDR_W'(i));
    end
  endgenerate

  // write wins over a coincident tick
  assign step = tick_i && !stop_q && !wr_en_i;

  rtc_bcd_field #(.W(8), .FLOOR(8'h00)) u_hund (
    .clk_i, .rst_ni, .inc_i(step), .ld_i(wr_en_i), .ld_val_i(8'h00),
    .ceil_i(8'h99), .val_o(hund_o), .wrap_o(w_hund));

  rtc_bcd_field #(.W(7), .FLOOR(7'h00)) u_sec (
    .clk_i, .rst_ni, .inc_i(w_hund), .ld_i(ld[A_SEC]), .ld_val_i(wr_data_i[6:0]),
    .ceil_i(7'h59), .val_o(sec_o), .wrap_o(w_sec));

  rtc_bcd_field #(.W(7), .FLOOR(7'h00)) u_min (
    .clk_i, .rst_ni, .inc_i(w_sec), .ld_i(ld[A_MIN]), .ld_val_i(wr_data_i[6:0]),
    .ceil_i(7'h59), .val_o(min_o), .wrap_o(w_min));

  rtc_bcd_field #(.W(6), .FLOOR(6'h00)) u_hour (
    .clk_i, .rst_ni, .inc_i(w_min), .ld_i(ld[A_HOUR]), .ld_val_i(wr_data_i[5:0]),
    .ceil_i(6'h23), .val_o(hour_o), .wrap_o(w_hour));

  rtc_month_len u_mlen (.month_i(month_o), .year_i(year_o), .last_day_o(last_day));

  rtc_bcd_field #(.W(6), .FLOOR(6'h01)) u_date (
    .clk_i, .rst_ni, .inc_i(w_hour), .ld_i(ld[A_DATE]), .ld_val_i(wr_data_i[5:0]),
    .ceil_i(last_day), .val_o(date_o), .wrap_o(w_date));

  rtc_bcd_field #(.W(5), .FLOOR(5'h01)) u_month (
    .clk_i, .rst_ni, .inc_i(w_date), .ld_i(ld[A_MONTH]), .ld_val_i(wr_data_i[4:0]),
    .ceil_i(5'h12), .val_o(month_o), .wrap_o(w_month));

  rtc_bcd_field #(.W(8), .FLOOR(8'h00)) u_year (
    .clk_i, .rst_ni, .inc_i(w_month), .ld_i(ld[A_YEAR]), .ld_val_i(wr_data_i),
    .ceil_i(8'h99), .val_o(year_o), .wrap_o(w_year));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dow_q     <= 3'd1;
      stop_q    <= 1'b0;
      cent_q    <= 1'b0;
      cent_en_q <= 1'b0;
      adv_q     <= 1'b0;
    end else begin
      adv_q <= step;
      if (ld[A_DOW])   dow_q <= wr_data_i[2:0];
      else if (w_hour) dow_q <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (ld[A_SEC])   stop_q <= wr_data_i[7];
      if (ld[A_HOUR]) begin
        cent_q    <= wr_data_i[7];
        cent_en_q <= wr_data_i[6];
      end else if (w_year && cent_en_q) begin
        cent_q <= ~cent_q;
      end
    end
  end

  assign dow_o     = dow_q;
  assign stop_o    = stop_q;
  assign cent_o    = cent_q;
  assign cent_en_o = cent_en_q;
  assign adv_o     = adv_q;
endmodule

// File: rtl/rtc_chain_chk.sv
module rtc_chain_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] hund_o,
  input logic [6:0] sec_o,
  input logic       stop_o,
  input logic [6:0] min_o,
  input logic [5:0] hour_o,
  input logic       cent_o,
  input logic       cent_en_o,
  input logic [2:0] dow_o,
  input logic [5:0] date_o,
  input logic [4:0] month_o,
  input logic [7:0] year_o,
  input logic       adv_o
);
  assert_wr_clears_hund_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (hund_o == 8'h00));

  assert_stop_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_o && !wr_en_i) |=> ($stable(hund_o) && $stable(sec_o) && $stable(min_o) &&
                              $stable(hour_o) && $stable(date_o) && !adv_o));

  assert_tick_dropped_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wr_en_i) |=> !adv_o);

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_en_i) |=> ($stable(hund_o) && !adv_o));

  assert_adv_source_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |-> ($past(tick_i) && !$past(wr_en_i) && !$past(stop_o)));

  assert_cent_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cent_en_o && !wr_en_i) |=> $stable(cent_o));

  assert_midnight_dow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_o && hour_o == 6'h00 && $past(hour_o) == 6'h23) |-> (dow_o != $past(dow_o)));
endmodule

bind rtc_bcd_chain rtc_chain_chk u_chk (.*);

// File: tb/sim_rtc_bcd_chain.sv
module sim_rtc_bcd_chain;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] hund, year;
  logic [6:0] sec, minute;
  logic [5:0] hour, date;
  logic [4:0] month;
  logic [2:0] dow;
  logic stop, cent, cent_en, adv;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hund_o(hund), .sec_o(sec), .stop_o(stop), .min_o(minute),
    .hour_o(hour), .cent_o(cent), .cent_en_o(cent_en), .dow_o(dow), .date_o(date),
    .month_o(month), .year_o(year), .adv_o(adv));

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_eve(input logic [7:0] hw, input logic [5:0] d, input logic [4:0] m,
                         input logic [7:0] y);
    wr(3'd1, 8'h59); wr(3'd2, 8'h59); wr(3'd3, hw); wr(3'd4, 8'h07);
    wr(3'd5, {2'b0, d}); wr(3'd6, {3'b0, m}); wr(3'd7, y);
  endtask

  task automatic t_reset();
    chk("R1", "hund", hund, 0);   chk("R1", "sec", sec, 0);     chk("R1", "min", minute, 0);
    chk("R1", "hour", hour, 0);   chk("R1", "dow", dow, 1);     chk("R1", "date", date, 1);
    chk("R1", "month", month, 1); chk("R1", "year", year, 0);   chk("R1", "cent", cent, 0);
    chk("R1", "cent_en", cent_en, 0); chk("R1", "stop", stop, 0); chk("R1", "adv", adv, 0);
  endtask

  task automatic t_count();
    run_ticks(5);
    chk("R2", "hund after 5", hund, 'h05);
    chk("R10", "adv after tick", adv, 1);
    @(negedge clk);
    chk("R10", "adv one cycle", adv, 0);
    run_ticks(95);
    chk("R2", "hund wrap", hund, 'h00);
    chk("R2", "sec carry", sec, 'h01);
  endtask

  task automatic t_midnight();
    set_eve(8'h23, 6'h15, 5'h03, 8'h21);
    run_ticks(99);
    chk("R8", "sec held 99 ticks", sec, 'h59);
    run_ticks(1);
    chk("R2", "sec wrap", sec, 'h00);  chk("R2", "min wrap", minute, 'h00);
    chk("R3", "hour wrap", hour, 'h00); chk("R3", "dow 7->1", dow, 1);
    chk("R3", "date inc", date, 'h16);
  endtask

  task automatic t_month(input logic [5:0] d, input logic [4:0] m, input logic [7:0] y,
                         input int exp_d, input int exp_m, input int exp_y, input string req);
    set_eve(8'h23, d, m, y);
    run_ticks(100);
    chk(req, "date", date, exp_d); chk(req, "month", month, exp_m); chk(req, "year", year, exp_y);
  endtask

  task automatic t_century();
    set_eve(8'h63, 6'h31, 5'h12, 8'h99);
    run_ticks(100);
    chk("R5", "year 99->00", year, 'h00);
    chk("R6", "cent toggles", cent, 1);
    set_eve(8'hA3, 6'h31, 5'h12, 8'h99);
    run_ticks(100);
    chk("R6", "cent held when disabled", cent, 1);
    chk("R6", "cent_en", cent_en, 0);
  endtask

  task automatic t_stop();
    wr(3'd1, 8'h90);
    chk("R11", "stop flag", stop, 1);
    run_ticks(10);
    chk("R7", "hund frozen", hund, 0); chk("R7", "sec frozen", sec, 'h10);
    chk("R7", "no adv", adv, 0);
    wr(3'd1, 8'h10);
    run_ticks(3);
    chk("R7", "resume", hund, 'h03);
  endtask

  task automatic t_collide();
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd2; wr_data = 8'h33;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    chk("R9", "written min", minute, 'h33);
    chk("R9", "hund cleared", hund, 0);
    chk("R9", "adv dropped", adv, 0);
    run_ticks(4);
    wr(3'd0, 8'h47);
    chk("R8", "hund write forced 00", hund, 0);
  endtask

  task automatic t_mask();
    wr(3'd2, 8'hB3); chk("R11", "min bit7 ignored", minute, 'h33);
    wr(3'd4, 8'hFD); chk("R11", "dow bits", dow, 5);
    wr(3'd6, 8'hE9); chk("R11", "month bits", month, 'h09);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_midnight();
    t_month(6'h28, 5'h02, 8'h24, 'h29, 'h02, 'h24, "R4");
    t_month(6'h29, 5'h02, 8'h24, 'h01, 'h03, 'h24, "R4");
    t_month(6'h28, 5'h02, 8'h23, 'h01, 'h03, 'h23, "R4");
    t_month(6'h28, 5'h02, 8'h00, 'h29, 'h02, 'h00, "R4");
    t_month(6'h28, 5'h02, 8'h16, 'h29, 'h02, 'h16, "R4");
    t_month(6'h30, 5'h04, 8'h10, 'h01, 'h05, 'h10, "R4");
    t_month(6'h30, 5'h11, 8'h10, 'h01, 'h12, 'h10, "R4");
    t_month(6'h31, 5'h01, 8'h10, 'h01, 'h02, 'h10, "R4");
    t_month(6'h30, 5'h08, 8'h10, 'h31, 'h08, 'h10, "R4");
    t_month(6'h31, 5'h12, 8'h05, 'h01, 'h01, 'h06, "R5");
    t_month(6'h31, 5'h12, 8'h19, 'h01, 'h01, 'h20, "R5");
    t_century();
    t_stop();
    t_collide();
    t_mask();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule